// File: doc/BRIEF.md
# Unslotted CSMA-CA Transmit Sequencer

This block runs one complete unslotted CSMA-CA transmit transaction for an 802.15.4 radio MAC. A start command, taken only while the block is idle, opens a transaction. The block waits out a MAC delay, then alternates random backoffs with clear-channel assessments. After a clear CCA it asks the radio to transmit, and when the frame requests it, it listens for an acknowledgement. It ends with one of five result codes and a one-cycle completion pulse. All timing counts pulses of a microsecond tick input. A timed wait of N ticks therefore takes N clock cycles when the tick is held high, and never less than one cycle.

A CCA retry loop sits inside a frame retry loop. A busy channel widens the backoff exponent, and a missing or mismatched acknowledgement restarts the channel-access procedure from scratch. A reserved CCA limit code skips the channel-access phase, so the transmission starts straight after the MAC delay. Random backoff lengths come from an internal 16-bit PRBS that advances once per draw. Its state persists from reset across transactions.

Top module: `csma_tx_seq`

## Requirements
- R1: After reset, `phase_o` is 0 (idle), and `done_o`, `tx_start_o`, `cca_en_o` and `rx_en_o` are all low.
- R2: `start_i` is acted on only in idle. In the receive-hold phase (`phase_o`=6) it has no effect, and the phase stays 6.
- R3: Bad configuration is rejected at start. A CCA limit of 6 is bad. When the CCA limit is not 7, a maximum exponent outside 3..8 is bad, and so is a minimum exponent above the maximum. In either case the block asserts `done_o` with status 4 in the next cycle and stays idle, even with turnaround set.
- R4: A valid start enters the delay phase (`phase_o`=1) for `dly_base_i`+`dly_ext_i` ticks.
- R5: Each backoff (`phase_o`=2) lasts D×320 ticks, where D is the low BE bits of the PRBS state. The PRBS is x^16+x^14+x^13+x^11+1. It shifts left, and the feedback bit is bit15^bit13^bit12^bit10, inserted at bit 0. It is seeded with 0xACE1 at reset and steps once per draw.
- R6: A CCA (`phase_o`=3, `cca_en_o` high) lasts 128 ticks, and `cca_busy_i` is sampled in its last cycle. On a busy result, the CCA count increments, BE becomes min(BE+1, maximum), and a new backoff is drawn.
- R7: When the channel is busy and the busy count already equals the CCA limit, the block finishes with status 2.
- R8: With a CCA limit of 7, the backoff and CCA phases are skipped on every attempt, and the exponent fields are ignored.
- R9: On entry to the transmit phase (`phase_o`=4), `tx_start_o` pulses for one cycle, and the block then waits for `tx_done_i`. The ACK request is bit 5 of `tx_fcf_hi_i`. If that bit is clear, the block finishes with status 0.
- R10: The ACK wait (`phase_o`=5, `rx_en_o` high) lasts up to 864 ticks. An ACK whose `ack_seq_i` equals `tx_seq_i` finishes the transaction. The status is 1 if `ack_pend_i` is set, and 0 if not.
- R11: A timeout or a sequence mismatch triggers a new channel-access attempt, with the CCA count reset and BE back at the minimum. After `frame_limit_i`+1 failed transmissions, the block finishes with status 3.
- R12: Every outcome gives a one-cycle `done_o` with `status_o` valid. Afterwards the block enters receive-hold (`phase_o`=6, `rx_en_o` high) if `turnaround_i` is set or the status is 1. Otherwise it returns to idle.
- R13: `abort_i` returns the block to idle in the next cycle from any phase. No `done_o` or `tx_start_o` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| us_tick_i | input | 1 | One-microsecond timing tick |
| start_i | input | 1 | Start a transaction |
| abort_i | input | 1 | Abandon the transaction |
| dly_base_i | input | DLY_W | Base MAC delay, ticks |
| dly_ext_i | input | DLY_W | Extension MAC delay, ticks |
| min_be_i | input | 4 | Minimum backoff exponent |
| max_be_i | input | 4 | Maximum backoff exponent |
| cca_limit_i | input | 3 | CCA retry limit; 7 skips channel access |
| frame_limit_i | input | 4 | Frame retry limit |
| turnaround_i | input | 1 | Enter receive after finishing |
| tx_fcf_hi_i | input | 8 | Second byte of the buffered frame |
| tx_seq_i | input | 8 | Sequence number of the buffered frame |
| cca_busy_i | input | 1 | CCA result, 1 = busy |
| tx_done_i | input | 1 | Frame transmission finished |
| ack_valid_i | input | 1 | ACK frame received |
| ack_seq_i | input | 8 | Sequence number of received ACK |
| ack_pend_i | input | 1 | Frame-pending bit of received ACK |
| cca_en_o | output | 1 | CCA measurement window |
| tx_start_o | output | 1 | Transmit start pulse |
| rx_en_o | output | 1 | Receiver enable |
| phase_o | output | 3 | Current phase code |
| done_o | output | 1 | Completion pulse |
| status_o | output | 3 | Result code |

## Verification
Two conditions are the hardest to reach from the ports: the CCA count being cleared between frame retries, and the PRBS stream continuing correctly across transactions and aborts. The bench pairs a CCA limit of 1 with a busy-then-clear channel on two consecutive frame attempts. A leaked busy count would then turn the second attempt into a channel-access failure. The bench advances its own integer model of the PRBS on every draw it expects, an aborted transaction included. Every later backoff length therefore depends on the whole history since reset.

// File: rtl/csma_pkg.sv
package csma_pkg;
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_DELAY   = 3'd1,
    PH_BACKOFF = 3'd2,
    PH_CCA     = 3'd3,
    PH_TX      = 3'd4,
    PH_ACK     = 3'd5,
    PH_RXHOLD  = 3'd6
  } phase_e;

  typedef enum logic [2:0] {
    RES_OK       = 3'd0,
    RES_OK_PEND  = 3'd1,
    RES_FAIL_CCA = 3'd2,
    RES_NO_ACK   = 3'd3,
    RES_BAD_CFG  = 3'd4
  } result_e;

  localparam int          PRBS_W     = 16;
  localparam logic [2:0]  CCA_OFF    = 3'd7;
  localparam logic [2:0]  CCA_BADLIM = 3'd6;
endpackage

// File: rtl/csma_tick_timer.sv
module csma_tick_timer #(
  parameter int CNT_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expired_o = (cnt_q == '0) || (tick_i && cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/csma_prbs.sv
module csma_prbs
  import csma_pkg::*;
#(
  parameter logic [PRBS_W-1:0] SEED = 16'hACE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  output logic [PRBS_W-1:0] state_o
);
  logic [PRBS_W-1:0] lfsr_q;
  logic              fb;

  // taps 16,14,13,11
  assign fb      = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];
  assign state_o = lfsr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lfsr_q <= SEED;
    else if (step_i) lfsr_q <= {lfsr_q[PRBS_W-2:0], fb};
  end
endmodule

// File: rtl/csma_cfg_chk.sv
module csma_cfg_chk
  import csma_pkg::*;
#(
  parameter int BE_W  = 4,
  parameter int BE_LO = 3,
  parameter int BE_HI = 8
) (
  input  logic [BE_W-1:0] min_be_i,
  input  logic [BE_W-1:0] max_be_i,
  input  logic [2:0]      cca_limit_i,
  output logic            bad_o
);
  logic be_bad;

  assign be_bad = (max_be_i < BE_W'(BE_LO)) || (max_be_i > BE_W'(BE_HI)) ||
                  (min_be_i > max_be_i);
  assign bad_o  = (cca_limit_i == CCA_BADLIM) || ((cca_limit_i != CCA_OFF) && be_bad);
endmodule

// File: rtl/csma_tx_seq.sv
module csma_tx_seq
  import csma_pkg::*;
#(
  parameter int                DLY_W       = 8,
  parameter int                BE_W        = 4,
  parameter int                FRM_W       = 4,
  parameter int                BE_LO       = 3,
  parameter int                BE_HI       = 8,
  parameter int                BO_US       = 320,
  parameter int                CCA_US      = 128,
  parameter int                ACK_US      = 864,
  parameter int                ACK_REQ_BIT = 5,
  parameter logic [PRBS_W-1:0] PRBS_SEED   = 16'hACE1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             us_tick_i,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [DLY_W-1:0] dly_base_i,
  input  logic [DLY_W-1:0] dly_ext_i,
  input  logic [BE_W-1:0]  min_be_i,
  input  logic [BE_W-1:0]  max_be_i,
  input  logic [2:0]       cca_limit_i,
  input  logic [FRM_W-1:0] frame_limit_i,
  input  logic             turnaround_i,
  input  logic [7:0]       tx_fcf_hi_i,
  input  logic [7:0]       tx_seq_i,
  input  logic             cca_busy_i,
  input  logic             tx_done_i,
  input  logic             ack_valid_i,
  input  logic [7:0]       ack_seq_i,
  input  logic             ack_pend_i,
  output logic             cca_en_o,
  output logic             tx_start_o,
  output logic             rx_en_o,
  output logic [2:0]       phase_o,
  output logic             done_o,
  output logic [2:0]       status_o
);
  localparam int BO_MAX = BO_US * ((1 << BE_HI) - 1);
  localparam int DLY_MAX = 2 * ((1 << DLY_W) - 1);
  localparam int T_MAX_A = (BO_MAX > ACK_US) ? BO_MAX : ACK_US;
  localparam int T_MAX_B = (T_MAX_A > CCA_US) ? T_MAX_A : CCA_US;
  localparam int T_MAX = (T_MAX_B > DLY_MAX) ? T_MAX_B : DLY_MAX;
  localparam int CNT_W = $clog2(T_MAX + 1);

  phase_e            ph_q, ph_d;
  logic [2:0]        nb_q, nb_d;
  logic [BE_W-1:0]   be_q, be_d, be_inc, be_draw;
  logic [FRM_W-1:0]  frm_q, frm_d;
  logic              done_q, tx_start_q;
  logic [2:0]        status_q;

  logic              tmr_load, tmr_exp;
  logic [CNT_W-1:0]  tmr_val, bo_ticks, dly_ticks;
  logic              prbs_step;
  logic [PRBS_W-1:0] prbs_state, be_mask, draw;
  logic              cfg_bad, bypass;
  logic              go_bo, go_tx, retry, fin;
  result_e           fin_code;
  logic              ack_match;

  csma_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (us_tick_i),
    .load_i    (tmr_load && !abort_i),
    .load_val_i(tmr_val),
    .expired_o (tmr_exp)
  );

  csma_prbs #(.SEED(PRBS_SEED)) u_prbs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (prbs_step && !abort_i),
    .state_o(prbs_state)
  );

  csma_cfg_chk #(.BE_W(BE_W), .BE_LO(BE_LO), .BE_HI(BE_HI)) u_cfg (
    .min_be_i   (min_be_i),
    .max_be_i   (max_be_i),
    .cca_limit_i(cca_limit_i),
    .bad_o      (cfg_bad)
  );

  assign bypass    = (cca_limit_i == CCA_OFF);
  assign be_inc    = (be_q >= max_be_i) ? max_be_i : be_q + BE_W'(1);
  assign ack_match = ack_valid_i && (ack_seq_i == tx_seq_i);
  assign be_mask   = (PRBS_W'(1) << be_draw) - PRBS_W'(1);
  assign draw      = prbs_state & be_mask;
  assign bo_ticks  = CNT_W'(draw) * CNT_W'(BO_US);
  assign dly_ticks = CNT_W'({1'b0, dly_base_i} + {1'b0, dly_ext_i});

  always_comb begin
    ph_d      = ph_q;
    nb_d      = nb_q;
    be_d      = be_q;
    frm_d     = frm_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    prbs_step = 1'b0;
    be_draw   = min_be_i;
    go_bo     = 1'b0;
    go_tx     = 1'b0;
    retry     = 1'b0;
    fin       = 1'b0;
    fin_code  = RES_OK;

    unique case (ph_q)
      PH_IDLE: if (start_i) begin
        if (cfg_bad) begin
          fin      = 1'b1;
          fin_code = RES_BAD_CFG;
        end else begin
          ph_d     = PH_DELAY;
          tmr_load = 1'b1;
          tmr_val  = dly_ticks;
          frm_d    = '0;
        end
      end
      PH_DELAY: if (tmr_exp) retry = 1'b1;
      PH_BACKOFF: if (tmr_exp) begin
        ph_d     = PH_CCA;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(CCA_US);
      end
      PH_CCA: if (tmr_exp) begin
        if (!cca_busy_i) go_tx = 1'b1;
        else if (nb_q == cca_limit_i) begin
          fin      = 1'b1;
          fin_code = RES_FAIL_CCA;
        end else begin
          nb_d    = nb_q + 3'd1;
          be_draw = be_inc;
          go_bo   = 1'b1;
        end
      end
      PH_TX: if (tx_done_i) begin
        if (tx_fcf_hi_i[ACK_REQ_BIT]) begin
          ph_d     = PH_ACK;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(ACK_US);
        end else begin
          fin = 1'b1;
        end
      end
      PH_ACK: begin
        if (ack_match) begin
          fin      = 1'b1;
          fin_code = ack_pend_i ? RES_OK_PEND : RES_OK;
        end else if (ack_valid_i || tmr_exp) begin
          if (frm_q == frame_limit_i) begin
            fin      = 1'b1;
            fin_code = RES_NO_ACK;
          end else begin
            frm_d = frm_q + FRM_W'(1);
            retry = 1'b1;
          end
        end
      end
      default: ;
    endcase

    // new channel-access attempt
    if (retry) begin
      nb_d = '0;
      if (bypass) go_tx = 1'b1;
      else begin
        be_draw = min_be_i;
        go_bo   = 1'b1;
      end
    end
    if (go_bo) begin
      ph_d      = PH_BACKOFF;
      be_d      = be_draw;
      tmr_load  = 1'b1;
      tmr_val   = bo_ticks;
      prbs_step = 1'b1;
    end
    if (go_tx) ph_d = PH_TX;
    if (fin) begin
      ph_d = (fin_code == RES_OK_PEND || (turnaround_i && fin_code != RES_BAD_CFG))
             ? PH_RXHOLD : PH_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q       <= PH_IDLE;
      nb_q       <= '0;
      be_q       <= '0;
      frm_q      <= '0;
      done_q     <= 1'b0;
      tx_start_q <= 1'b0;
      status_q   <= RES_OK;
    end else if (abort_i) begin
      ph_q       <= PH_IDLE;
      done_q     <= 1'b0;
      tx_start_q <= 1'b0;
    end else begin
      ph_q       <= ph_d;
      nb_q       <= nb_d;
      be_q       <= be_d;
      frm_q      <= frm_d;
      done_q     <= fin;
      tx_start_q <= go_tx;
      if (fin) status_q <= fin_code;
    end
  end

  assign phase_o    = ph_q;
  assign cca_en_o   = (ph_q == PH_CCA);
  assign rx_en_o    = (ph_q == PH_ACK) || (ph_q == PH_RXHOLD);
  assign done_o     = done_q;
  assign tx_start_o = tx_start_q;
  assign status_o   = status_q;
endmodule

// File: rtl/csma_tx_seq_chk.sv
module csma_tx_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       abort_i,
  input logic [2:0] phase_o,
  input logic       done_o,
  input logic [2:0] status_o,
  input logic       tx_start_o,
  input logic       cca_en_o
);
  p_abort_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (phase_o == 3'd0 && !done_o && !tx_start_o));

  p_hold_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd6 && !abort_i) |=> phase_o == 3'd6);

  p_txstart_entry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> (phase_o == 3'd4 && $past(phase_o) != 3'd4));

  p_cca_after_backoff_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cca_en_o) |-> $past(phase_o) == 3'd2);

  p_ack_after_tx_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd5 && $past(phase_o) != 3'd5) |-> $past(phase_o) == 3'd4);

  p_cfg_err_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == 3'd4) |-> (phase_o == 3'd0 && $past(phase_o) == 3'd0));

  p_noack_from_ack_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == 3'd3) |-> $past(phase_o) == 3'd5);

  p_ccafail_from_cca_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == 3'd2) |-> $past(phase_o) == 3'd3);

  p_delay_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd1 && $past(phase_o) != 3'd1) |-> ($past(phase_o) == 3'd0 && $past(start_i)));
endmodule

bind csma_tx_seq csma_tx_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .abort_i   (abort_i),
  .phase_o   (phase_o),
  .done_o    (done_o),
  .status_o  (status_o),
  .tx_start_o(tx_start_o),
  .cca_en_o  (cca_en_o)
);

// File: tb/tb_csma_tx_seq.sv
module tb_csma_tx_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, abort = 1'b0;
  logic [7:0] dly_base = 8'd20, dly_ext = 8'd12;
  logic [3:0] min_be = 4'd3, max_be = 4'd3;
  logic [2:0] cca_limit = 3'd4;
  logic [3:0] frame_limit = 4'd3;
  logic       turnaround = 1'b0;
  logic [7:0] fcf_hi = 8'h00, tx_seq = 8'h5A;
  logic       cca_busy = 1'b0, tx_done = 1'b0, ack_valid = 1'b0, ack_pend = 1'b0;
  logic [7:0] ack_seq = 8'h00;
  logic       cca_en, tx_start, rx_en, done;
  logic [2:0] phase, status;

  int errors = 0;
  int checks = 0;
  int m_lfsr = 16'hACE1;
  int busy_q[$];
  int ack_q[$];  // 0 timeout, 1 match, 2 match+pending, 3 wrong sequence

  always #2 clk = ~clk;

  csma_tx_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .us_tick_i(1'b1), .start_i(start), .abort_i(abort),
    .dly_base_i(dly_base), .dly_ext_i(dly_ext), .min_be_i(min_be), .max_be_i(max_be),
    .cca_limit_i(cca_limit), .frame_limit_i(frame_limit), .turnaround_i(turnaround),
    .tx_fcf_hi_i(fcf_hi), .tx_seq_i(tx_seq), .cca_busy_i(cca_busy), .tx_done_i(tx_done),
    .ack_valid_i(ack_valid), .ack_seq_i(ack_seq), .ack_pend_i(ack_pend),
    .cca_en_o(cca_en), .tx_start_o(tx_start), .rx_en_o(rx_en), .phase_o(phase),
    .done_o(done), .status_o(status)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  function automatic int draw(input int be);
    int d, fb;
    d = m_lfsr & ((1 << be) - 1);
    fb = ((m_lfsr >> 15) ^ (m_lfsr >> 13) ^ (m_lfsr >> 12) ^ (m_lfsr >> 10)) & 1;
    m_lfsr = ((m_lfsr << 1) | fb) & 16'hFFFF;
    return d;
  endfunction

  // one clock of expected behaviour, checked at the falling edge
  task automatic cyc(input int ph, input int txs, input string tag);
    @(negedge clk);
    start = 1'b0; abort = 1'b0; tx_done = 1'b0; ack_valid = 1'b0;
    chk({tag, " phase"}, phase, ph);
    chk({tag, " cca_en"}, cca_en, (ph == 3) ? 1 : 0);
    chk({tag, " rx_en"}, rx_en, (ph == 5 || ph == 6) ? 1 : 0);
    chk({tag, " tx_start"}, tx_start, txs);
    chk({tag, " done"}, done, 0);
  endtask

  task automatic fin_chk(input int code, input string tag);
    int hold;
    hold = (code == 1 || (turnaround && code != 4)) ? 1 : 0;
    @(negedge clk);
    start = 1'b0; abort = 1'b0; tx_done = 1'b0; ack_valid = 1'b0;
    chk({tag, " R12 done"}, done, 1);
    chk({tag, " status"}, status, code);
    chk({tag, " R12 phase"}, phase, hold ? 6 : 0);
  endtask

  task automatic run_txn(input string tag);
    int dmac, p, nb, be, frm, code, b, k, n;
    bit fin;
    start = 1'b1;
    dmac = dly_base + dly_ext;
    if (dmac < 1) dmac = 1;
    repeat (dmac) cyc(1, 0, "R4");
    frm = 0; fin = 0; code = 0;
    forever begin
      if (cca_limit != 3'd7) begin
        nb = 0; be = min_be;
        forever begin
          p = draw(be);
          n = p * 320; if (n < 1) n = 1;
          repeat (n) cyc(2, 0, "R5");
          cyc(3, 0, "R6");
          b = busy_q.pop_front();
          cca_busy = b[0];
          repeat (127) cyc(3, 0, "R6");
          if (b == 0) break;
          if (nb == cca_limit) begin code = 2; fin = 1; break; end
          nb++;
          be = (be + 1 > max_be) ? max_be : be + 1;
        end
      end else begin
        // R8: no backoff/CCA phases expected
      end
      if (fin) break;
      cyc(4, 1, "R9");
      repeat (3) cyc(4, 0, "R9");
      tx_done = 1'b1;
      if (!fcf_hi[5]) begin code = 0; break; end
      k = ack_q.pop_front();
      if (k == 0) repeat (864) cyc(5, 0, "R10");
      else begin
        repeat (6) cyc(5, 0, "R10");
        ack_valid = 1'b1;
        ack_seq = (k == 3) ? 8'hA5 : tx_seq;
        ack_pend = (k == 2);
      end
      if (k == 1 || k == 2) begin code = (k == 2) ? 1 : 0; break; end
      if (frm == frame_limit) begin code = 3; break; end
      frm++;
    end
    fin_chk(code, tag);
  endtask

  task automatic err_txn(input string tag);
    start = 1'b1;
    fin_chk(4, tag);
    cyc(0, 0, "R3");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset phase", phase, 0);
    chk("R1 reset done", done, 0);
    rst_n = 1'b1;
    cyc(0, 0, "R1");
    cyc(0, 0, "R1");

    // plain transmission, no ACK requested
    busy_q = {0};
    run_txn("R9 noack-req");
    chk("R9 status ok", status, 0);

    // exponent growth and saturation
    min_be = 4'd2; max_be = 4'd3;
    busy_q = {1, 1, 0};
    run_txn("R6 be-growth");

    // channel-access failure
    cca_limit = 3'd1; min_be = 4'd1; max_be = 4'd3;
    busy_q = {1, 1};
    run_txn("R7 cca-fail");

    // bypass with bogus exponents, ACK with pending data -> receive hold
    cca_limit = 3'd7; min_be = 4'd9; max_be = 4'd2; fcf_hi = 8'h20;
    ack_q = {2};
    run_txn("R8 bypass-pend R10");
    start = 1'b1;
    cyc(6, 0, "R2");
    start = 1'b1;
    cyc(6, 0, "R2");
    abort = 1'b1;
    cyc(0, 0, "R13");

    // wrong sequence, then timeout, limit reached
    fcf_hi = 8'h21; frame_limit = 4'd1;
    ack_q = {3, 0};
    run_txn("R11 noack");

    // CCA count cleared between frame retries, turnaround after success
    cca_limit = 3'd1; min_be = 4'd0; max_be = 4'd3; frame_limit = 4'd2;
    fcf_hi = 8'h20; turnaround = 1'b1;
    busy_q = {1, 0, 1, 0};
    ack_q = {3, 1};
    run_txn("R11 nb-reset R12");
    abort = 1'b1;
    cyc(0, 0, "R13");

    // configuration errors
    cca_limit = 3'd6; min_be = 4'd3; max_be = 4'd5;
    err_txn("R3 lim6");
    cca_limit = 3'd3; max_be = 4'd9;
    err_txn("R3 maxbe9");
    min_be = 4'd5; max_be = 4'd4;
    err_txn("R3 min>max");
    turnaround = 1'b0;

    // abort in the middle of a CCA window
    cca_limit = 3'd4; min_be = 4'd3; max_be = 4'd3; fcf_hi = 8'h00;
    begin
      int p, n;
      start = 1'b1;
      repeat (32) cyc(1, 0, "R4");
      p = draw(3);
      n = p * 320; if (n < 1) n = 1;
      repeat (n) cyc(2, 0, "R5");
      repeat (3) cyc(3, 0, "R6");
      abort = 1'b1;
      cyc(0, 0, "R13");
      cyc(0, 0, "R13");
    end

    // PRBS continues across transactions
    busy_q = {0};
    run_txn("R5 continuity");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule